// File: doc/BRIEF.md
# Edge-Triggered Interrupt Message Generator

This block turns low-to-high transitions on a bank of interrupt pins into delivery messages for a downstream interrupt fabric. Each pin has a routing entry, supplied as one flat bus from an external table. The entry gives the vector, the delivery mode, the destination mode, the destination ID, the polarity, the trigger mode and a mask bit.

When a pin goes from low to high, the block checks the pin's mask bit. A masked transition is dropped, and nothing of it is kept. An unmasked transition becomes a pending event. Pending events are drained one at a time, lowest pin number first, into a registered message output that uses a valid/ready handshake. In pass-through delivery mode the message vector comes from an external legacy controller's vector input instead of the entry.

Resolving which processor receives the message is done elsewhere. Repeated sending for level-sensitive sources is also done elsewhere.

Top module: `irq_msg_gen`

## Requirements
- R1: While `rst_n` is low, `msg_valid` is 0 and every remembered pin state is low. A pin that is already high when reset is released therefore counts as a rising transition and produces one message.
- R2: A message is produced only when a pin is sampled high after being sampled low on the previous clock. A pin that stays high produces no further messages.
- R3: A rising transition on a pin whose entry has the mask bit (bit 14) set is discarded. Clearing the mask later, while the pin stays high, delivers nothing.
- R4: When the entry's 3-bit delivery mode (bits 10:8) equals 3'b111, `msg_vector` is taken from `ext_vector` at the cycle the message is loaded. Otherwise it is the entry's vector field (bits 7:0).
- R5: The message fields come from the routing entry:
  - `msg_dmode` is the delivery mode (bits 10:8).
  - `msg_dest_logical` is the destination-mode bit (bit 11).
  - `msg_dest` is the destination (bits 22:15).
  - `msg_level` is the polarity bit (bit 12).
  - `msg_trigger` is the trigger-mode bit (bit 13).
- R6: Events pending on several pins are delivered in ascending pin order, one message per accepted handshake.
- R7: While `msg_valid` is high and `msg_ready` is low, every message output holds its value. Pending events are kept until they are delivered, so no edge is lost under backpressure.
- R8: A second rising transition on a pin whose earlier event has not yet been delivered merges with it and yields a single message.
- R9: With the output free, `msg_valid` rises on the second clock edge counting the edge that first samples the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NPINS | Interrupt pin levels, sampled each clock |
| route_tbl | input | NPINS*23 | Routing entries; entry i occupies bits [i*23 +: 23] |
| ext_vector | input | 8 | Vector from the external legacy controller |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_dest_logical | output | 1 | Destination mode (1 = logical) |
| msg_dest | output | 8 | Destination ID |
| msg_level | output | 1 | Level bit (from entry polarity) |
| msg_trigger | output | 1 | Trigger-mode bit |

## Verification
The hardest case to reach is a pin that rises, falls and rises again while its first event is still waiting behind a stalled output. To get there, the bench first holds `msg_ready` low and occupies the output register with a message from another pin. It then toggles the target pin twice before releasing backpressure, and expects exactly one message for that pin. Dropped masked edges are reached by leaving a masked pin high and then clearing its mask. The output must then stay silent for many cycles.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int DMODE_W = 3;
  localparam logic [DMODE_W-1:0] DM_PASSTHRU = 3'b111;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic               mask;
    logic               trigger;
    logic               polarity;
    logic               dest_logical;
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vector;
  } route_ent_t;

  localparam int ENT_W = $bits(route_ent_t);

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DMODE_W-1:0] dmode;
    logic               dest_logical;
    logic [DEST_W-1:0]  dest;
    logic               level;
    logic               trigger;
  } irq_msg_t;

  localparam int MSG_W = $bits(irq_msg_t);
endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] grant,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] pend
);
  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] pend_d;

  // Edge against last sample; masked edges never reach the pending set.
  always_comb begin
    rise   = pins & ~pin_q;
    pend_d = (pend_q & ~grant) | (rise & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      pend_q <= '0;
    end else begin
      pin_q  <= pins;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NPINS = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             en,
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] grant,
  output logic [IDX_W-1:0] idx
);
  logic found;

  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (en && req[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_msg_fmt.sv
module irq_msg_fmt
  import irq_msg_pkg::*;
(
  input  route_ent_t       ent,
  input  logic [VEC_W-1:0] ext_vec,
  output irq_msg_t         msg
);
  always_comb begin
    msg.vector       = (ent.dmode == DM_PASSTHRU) ? ext_vec : ent.vector;
    msg.dmode        = ent.dmode;
    msg.dest_logical = ent.dest_logical;
    msg.dest         = ent.dest;
    msg.level        = ent.polarity;
    msg.trigger      = ent.trigger;
  end
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
  import irq_msg_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       irq_pins,
  input  logic [NPINS*ENT_W-1:0] route_tbl,
  input  logic [VEC_W-1:0]       ext_vector,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [VEC_W-1:0]       msg_vector,
  output logic [DMODE_W-1:0]     msg_dmode,
  output logic                   msg_dest_logical,
  output logic [DEST_W-1:0]      msg_dest,
  output logic                   msg_level,
  output logic                   msg_trigger
);
  route_ent_t       ents [NPINS];
  logic [NPINS-1:0] mask_vec;
  logic [NPINS-1:0] rise_vec;
  logic [NPINS-1:0] pend_vec;
  logic [NPINS-1:0] grant_vec;
  logic [IDX_W-1:0] grant_idx;
  logic             out_free;
  logic             load;
  route_ent_t       sel_ent;
  irq_msg_t         fmt_msg;
  logic             valid_q, valid_d;
  irq_msg_t         msg_q, msg_d;

  for (genvar g = 0; g < NPINS; g++) begin : g_unpack
    assign ents[g]     = route_tbl[g*ENT_W +: ENT_W];
    assign mask_vec[g] = ents[g].mask;
  end

  irq_edge_track #(.NPINS(NPINS)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  (irq_pins),
    .mask  (mask_vec),
    .grant (grant_vec),
    .rise  (rise_vec),
    .pend  (pend_vec)
  );

  assign out_free = !valid_q || msg_ready;

  irq_pick #(.NPINS(NPINS)) u_pick (
    .en    (out_free),
    .req   (pend_vec),
    .grant (grant_vec),
    .idx   (grant_idx)
  );

  assign load    = |grant_vec;
  assign sel_ent = ents[grant_idx];

  irq_msg_fmt u_fmt (
    .ent     (sel_ent),
    .ext_vec (ext_vector),
    .msg     (fmt_msg)
  );

  always_comb begin
    valid_d = valid_q;
    msg_d   = msg_q;
    if (load) begin
      valid_d = 1'b1;
      msg_d   = fmt_msg;
    end else if (msg_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= '0;
    end else if (load) begin
      msg_q <= msg_d;
    end
  end

  assign msg_valid        = valid_q;
  assign msg_vector       = msg_q.vector;
  assign msg_dmode        = msg_q.dmode;
  assign msg_dest_logical = msg_q.dest_logical;
  assign msg_dest         = msg_q.dest;
  assign msg_level        = msg_q.level;
  assign msg_trigger      = msg_q.trigger;
endmodule

// File: rtl/irq_msg_gen_chk.sv
module irq_msg_gen_chk
  import irq_msg_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [MSG_W-1:0] msg_q,
  input logic [NPINS-1:0] rise_vec,
  input logic [NPINS-1:0] mask_vec,
  input logic [NPINS-1:0] pend_vec,
  input logic [NPINS-1:0] grant_vec
);
  logic [NPINS-1:0] masked_new;
  logic [NPINS-1:0] waiting;

  assign masked_new = rise_vec & mask_vec & ~pend_vec;
  assign waiting    = pend_vec & ~grant_vec;

  // R7: stalled output holds
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));

  // R7: pending events survive until granted
  a_r7_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting != '0) |=> (($past(waiting) & ~pend_vec) == '0));

  // R3: masked edge never becomes pending
  a_r3_masked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_new != '0) |=> ((pend_vec & $past(masked_new)) == '0));

  // R6: grant is one pending pin with no lower pending pin
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> ($onehot0(grant_vec) && ((grant_vec & pend_vec) != '0)
                           && (((grant_vec - 1'b1) & pend_vec) == '0)));

  // R2: a new message only follows a pending event
  a_r2_valid_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ($past(pend_vec) != '0));
endmodule

bind irq_msg_gen irq_msg_gen_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_q     (msg_q),
  .rise_vec  (rise_vec),
  .mask_vec  (mask_vec),
  .pend_vec  (pend_vec),
  .grant_vec (grant_vec)
);

// File: tb/irq_msg_gen_test.sv
module irq_msg_gen_test;
  localparam int N  = 8;
  localparam int EW = 23;

  logic            clk;
  logic            rst_r;
  logic [N-1:0]    pins_r;
  logic [N*EW-1:0] tbl;
  logic [7:0]      ext_r;
  logic            ready_r;
  logic            msg_valid;
  logic [7:0]      msg_vector;
  logic [2:0]      msg_dmode;
  logic            msg_dest_logical;
  logic [7:0]      msg_dest;
  logic            msg_level;
  logic            msg_trigger;

  irq_msg_gen #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_r), .irq_pins(pins_r), .route_tbl(tbl),
    .ext_vector(ext_r), .msg_valid(msg_valid), .msg_ready(ready_r),
    .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest),
    .msg_level(msg_level), .msg_trigger(msg_trigger)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_prev [N];
  bit m_pend [N];
  bit m_ov;
  int m_vec, m_dm, m_dl, m_dst, m_lvl, m_trg;
  bit prev_dut_valid;
  int prev_dut_vec;
  int acc[$];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic [EW-1:0] mk(int vec, int dm, int dl, int pol, int trg, int msk, int dst);
    logic [EW-1:0] e;
    e[7:0]   = vec[7:0];
    e[10:8]  = dm[2:0];
    e[11]    = dl[0];
    e[12]    = pol[0];
    e[13]    = trg[0];
    e[14]    = msk[0];
    e[22:15] = dst[7:0];
    return e;
  endfunction

  task automatic model_step();
    bit found;
    logic [EW-1:0] e;
    if (prev_dut_valid && ready_r && rst_r) acc.push_back(prev_dut_vec);
    if (!rst_r) begin
      for (int i = 0; i < N; i++) begin m_prev[i] = 0; m_pend[i] = 0; end
      m_ov = 0;
      return;
    end
    found = 0;
    if (!m_ov || ready_r) begin
      m_ov = 0;
      for (int i = 0; i < N; i++) begin
        if (m_pend[i] && !found) begin
          found = 1;
          m_pend[i] = 0;
          e = tbl[i*EW +: EW];
          m_ov  = 1;
          m_dm  = e[10:8];
          m_vec = (m_dm == 7) ? ext_r : e[7:0];
          m_dl  = e[11];
          m_dst = e[22:15];
          m_lvl = e[12];
          m_trg = e[13];
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      e = tbl[i*EW +: EW];
      if (pins_r[i] && !m_prev[i] && !e[14]) m_pend[i] = 1;
      m_prev[i] = pins_r[i];
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    chk(msg_valid == m_ov, cur_req, msg_valid, m_ov);
    if (m_ov && msg_valid) begin
      chk(msg_vector == m_vec, (m_dm == 7) ? "R4" : "R5", msg_vector, m_vec);
      chk(msg_dmode == m_dm, "R5", msg_dmode, m_dm);
      chk(msg_dest_logical == m_dl, "R5", msg_dest_logical, m_dl);
      chk(msg_dest == m_dst, "R5", msg_dest, m_dst);
      chk(msg_level == m_lvl, "R5", msg_level, m_lvl);
      chk(msg_trigger == m_trg, "R5", msg_trigger, m_trg);
    end
    prev_dut_valid = msg_valid;
    prev_dut_vec   = msg_vector;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int v;
    rst_r = 1'b1; pins_r = '0; ready_r = 1'b1; ext_r = 8'h00;
    prev_dut_valid = 0; prev_dut_vec = 0; m_ov = 0;
    for (int i = 0; i < N; i++) tbl[i*EW +: EW] = mk(8'h20 + i, 0, 0, 0, 0, 0, i);
    tbl[2*EW +: EW] = mk(8'h22, 1, 1, 1, 0, 0, 8'h5A);
    tbl[3*EW +: EW] = mk(8'h23, 2, 0, 0, 1, 1, 8'h13);
    tbl[4*EW +: EW] = mk(8'h24, 7, 0, 1, 1, 0, 8'h44);
    #1 rst_r = 1'b0;

    // R1: idle in reset, pin high at release counts as an edge
    cur_req = "R1";
    pins_r[0] = 1'b1;
    repeat (3) cyc();
    chk(msg_valid == 1'b0, "R1", msg_valid, 0);
    acc.delete();
    rst_r = 1'b1;
    repeat (4) cyc();
    chk(acc.size() == 1, "R1", acc.size(), 1);
    if (acc.size() > 0) chk(acc[0] == 8'h20, "R1", acc[0], 8'h20);

    // R9 latency, R2 no repeat while held, R5 fields
    cur_req = "R9";
    acc.delete();
    pins_r[2] = 1'b1;
    cyc();
    chk(msg_valid == 1'b0, "R9", msg_valid, 0);
    cyc();
    chk(msg_valid == 1'b1, "R9", msg_valid, 1);
    chk(msg_dest == 8'h5A && msg_level == 1'b1, "R5", {msg_dest, msg_level}, {8'h5A, 1'b1});
    cur_req = "R2";
    repeat (8) cyc();
    chk(acc.size() == 1, "R2", acc.size(), 1);

    // R3 masked edge is dropped even after unmask
    cur_req = "R3";
    acc.delete();
    pins_r[3] = 1'b1;
    repeat (4) cyc();
    tbl[3*EW + 14] = 1'b0;
    repeat (8) cyc();
    chk(acc.size() == 0, "R3", acc.size(), 0);

    // R4 pass-through vector
    cur_req = "R4";
    acc.delete();
    ext_r = 8'hA5;
    pins_r[4] = 1'b1;
    repeat (5) cyc();
    chk(acc.size() == 1, "R4", acc.size(), 1);
    if (acc.size() > 0) chk(acc[0] == 8'hA5, "R4", acc[0], 8'hA5);
    pins_r = '0;
    repeat (2) cyc();

    // R6 simultaneous edges, ascending order
    cur_req = "R6";
    acc.delete();
    pins_r = 8'b0110_0010;
    repeat (8) cyc();
    chk(acc.size() == 3, "R6", acc.size(), 3);
    if (acc.size() == 3) begin
      chk(acc[0] == 8'h21, "R6", acc[0], 8'h21);
      chk(acc[1] == 8'h25, "R6", acc[1], 8'h25);
      chk(acc[2] == 8'h26, "R6", acc[2], 8'h26);
    end

    // R7 backpressure
    cur_req = "R7";
    pins_r = '0;
    cyc();
    ready_r = 1'b0;
    pins_r[2] = 1'b1;
    pins_r[3] = 1'b1;
    repeat (3) cyc();
    v = msg_vector;
    repeat (6) cyc();
    chk(msg_valid == 1'b1 && msg_vector == v && v == 8'h22, "R7", msg_vector, 8'h22);
    acc.delete();
    ready_r = 1'b1;
    repeat (5) cyc();
    chk(acc.size() == 2, "R7", acc.size(), 2);
    if (acc.size() == 2) chk(acc[1] == 8'h23, "R7", acc[1], 8'h23);

    // R8 re-rise while pending merges
    cur_req = "R8";
    pins_r = '0;
    cyc();
    ready_r = 1'b0;
    pins_r[0] = 1'b1;
    repeat (3) cyc();
    pins_r[7] = 1'b1; cyc();
    pins_r[7] = 1'b0; cyc();
    pins_r[7] = 1'b1; cyc();
    acc.delete();
    ready_r = 1'b1;
    repeat (6) cyc();
    chk(acc.size() == 2, "R8", acc.size(), 2);
    if (acc.size() == 2) chk(acc[1] == 8'h27, "R8", acc[1], 8'h27);

    summary();
  end
endmodule